// File: doc/BRIEF.md
# Wide Parallel PRBS Generator

This block produces a pseudo-random binary sequence at 128 bits per clock and presents it as sixteen byte-wide lanes. The bits are placed so that a downstream serializer, which takes one bit from each lane in turn, emits one unbroken sequence of the chosen pattern. A two-bit select picks one of four maximal-length recurrences of length 7, 15, 23 or 31.

A 31-bit history register holds the most recent serial bits. Each clock, a combinational look-ahead unrolls 128 steps of the selected recurrence. It writes those bits into the lane register and keeps the newest 31 bits as the next history. Reset and any change of the select load an all-ones seed, so the history can never reach the all-zero lock-up state. The cycle in which a change of select is seen produces an all-zero word as a marker.

Top module: `wide_prbs_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `lanes_o` becomes all zeros on that edge and the history is loaded with all ones.
- R2: With select 0, the first word after reset continues from an all-ones history: serial bits 0 to 5 are 0 and serial bit 6 is 1. So `lanes_o[127]` is 0 and `lanes_o[79]` is 1.
- R3: Select 0 produces serial bits s[n] = s[n-7] XOR s[n-6].
- R4: Select 1 produces serial bits s[n] = s[n-15] XOR s[n-14].
- R5: Select 2 produces serial bits s[n] = s[n-23] XOR s[n-18].
- R6: Select 3 produces serial bits s[n] = s[n-31] XOR s[n-28].
- R7: Serial bit k of a word (k = 0..127) sits in lane 15 - (k mod 16), at bit 7 - (k div 16) of that lane. Lane L occupies `lanes_o[8L+7:8L]`, so serial bit k is at flat index 8*(15 - k mod 16) + 7 - k div 16.
- R8: While the select is steady, consecutive words form one continuous sequence. The recurrence holds across word boundaries.
- R9: In a cycle where `sel` differs from the value seen in the previous cycle, the next `lanes_o` is all zeros and the history is reseeded to all ones. The following word starts the new pattern from that seed.
- R10: A word produced while the select is steady is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Pattern select, 0 to 3 |
| lanes_o | output | 128 | Sixteen registered 8-bit lanes, lane L at bits 8L+7..8L |

## Verification
The assertions assume that `rst` is high from the first clock edge, so that their one- and two-cycle look-backs at `sel` always refer to cycles the block has seen. They also assume `sel` is a clean synchronous input that changes only between edges. The stimulus holds reset for the first several edges and drives `rst` and `sel` only on falling edges. Beyond long steady runs in each pattern, it includes back-to-back select changes, repeated values after a change, and a reset in the middle of a run.

// File: rtl/wide_prbs_gen.sv
module wide_prbs_gen #(
  parameter int LANES   = 16,
  parameter int LANE_W  = 8,
  parameter int STATE_W = 31
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                sel,
  output logic [LANES*LANE_W-1:0]   lanes_o
);
  localparam int WORD = LANES * LANE_W;
  localparam int EXT  = STATE_W + WORD;

  logic [STATE_W-1:0] hist;
  logic [STATE_W-1:0] hist_nx;
  logic [1:0]         sel_q;
  logic [EXT-1:0]     ext;
  logic [WORD-1:0]    word;

  wire sel_change = (sel != sel_q);

  // ext[0] is the oldest history bit, ext[EXT-1] the newest generated bit
  always_comb begin
    ext = '0;
    for (int j = 0; j < STATE_W; j++) ext[j] = hist[STATE_W-1-j];
    case (sel)
      2'd0:    for (int j = STATE_W; j < EXT; j++) ext[j] = ext[j-7]  ^ ext[j-6];
      2'd1:    for (int j = STATE_W; j < EXT; j++) ext[j] = ext[j-15] ^ ext[j-14];
      2'd2:    for (int j = STATE_W; j < EXT; j++) ext[j] = ext[j-23] ^ ext[j-18];
      default: for (int j = STATE_W; j < EXT; j++) ext[j] = ext[j-31] ^ ext[j-28];
    endcase
    word = '0;
    for (int k = 0; k < WORD; k++)
      word[(LANES-1-(k%LANES))*LANE_W + LANE_W-1-(k/LANES)] = ext[STATE_W+k];
    for (int i = 0; i < STATE_W; i++) hist_nx[i] = ext[EXT-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst || sel_change) begin
      hist    <= '1;
      sel_q   <= sel;
      lanes_o <= '0;
    end else begin
      hist    <= hist_nx;
      lanes_o <= word;
    end
  end
endmodule

module wide_prbs_gen_chk (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   sel,
  input logic [127:0] lanes_o
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (lanes_o == '0));

  a_r9_switch_gap: assert property (@(posedge clk) disable iff (rst)
    (sel != $past(sel)) |=> (lanes_o == '0));

  a_r10_nonzero: assert property (@(posedge clk) disable iff (rst)
    (sel == $past(sel)) |=> (lanes_o != '0));

  // R8: first bit of the next word follows from bits 121 and 122 of the previous one
  a_r8_seam: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sel == 2'd0 && $past(sel) == 2'd0 && $past(sel, 2) == 2'd0)
    |=> (lanes_o[127] == ($past(lanes_o[48]) ^ $past(lanes_o[40]))));
endmodule

bind wide_prbs_gen wide_prbs_gen_chk u_chk (
  .clk(clk), .rst(rst), .sel(sel), .lanes_o(lanes_o)
);

// File: tb/tb_wide_prbs_gen.sv
`timescale 1ns/1ps
module tb_wide_prbs_gen;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   sel = 2'd0;
  logic [127:0] lanes_o;

  int vectors = 0;
  int checks  = 0;
  int fails   = 0;

  logic [30:0]  m_hist = '1;
  logic [1:0]   m_sel  = 2'd0;

  logic [127:0] q_word[$];
  int           q_kind[$];
  logic [1:0]   q_sel[$];

  always #4 clk = ~clk;

  wide_prbs_gen dut (.clk(clk), .rst(rst), .sel(sel), .lanes_o(lanes_o));

  task automatic drive(input logic r, input logic [1:0] s);
    logic [127:0] e;
    int kind;
    @(negedge clk);
    rst = r;
    sel = s;
    e = '0;
    if (r) begin
      m_hist = '1; m_sel = s; kind = 0;
    end else if (s != m_sel) begin
      m_hist = '1; m_sel = s; kind = 1;
    end else begin
      kind = 2;
      for (int k = 0; k < 128; k++) begin
        logic nb;
        case (s)
          2'd0:    nb = m_hist[6]  ^ m_hist[5];
          2'd1:    nb = m_hist[14] ^ m_hist[13];
          2'd2:    nb = m_hist[22] ^ m_hist[17];
          default: nb = m_hist[30] ^ m_hist[27];
        endcase
        m_hist = {m_hist[29:0], nb};
        e[(15 - k % 16) * 8 + 7 - k / 16] = nb;
      end
    end
    q_word.push_back(e);
    q_kind.push_back(kind);
    q_sel.push_back(s);
    vectors++;
  endtask

  always @(posedge clk) begin
    #1;
    if (q_word.size() > 0) begin
      logic [127:0] e;
      int kind;
      logic [1:0] s;
      string tag;
      e = q_word.pop_front();
      kind = q_kind.pop_front();
      s = q_sel.pop_front();
      if (kind == 0) tag = "R1";
      else if (kind == 1) tag = "R9";
      else case (s)
        2'd0: tag = "R3 R7 R8";
        2'd1: tag = "R4 R7 R8";
        2'd2: tag = "R5 R7 R8";
        default: tag = "R6 R7 R8";
      endcase
      checks++;
      if (lanes_o !== e) begin
        fails++;
        $display("FAIL %s got %h exp %h", tag, lanes_o, e);
      end
      if (kind == 2) begin
        checks++;
        if (lanes_o == '0) begin
          fails++;
          $display("FAIL R10 got %h exp nonzero", lanes_o);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) drive(1'b1, 2'd0);
    drive(1'b0, 2'd0);
    @(posedge clk); #2;
    checks++;
    if (lanes_o[127] !== 1'b0 || lanes_o[79] !== 1'b1) begin
      fails++;
      $display("FAIL R2 got %b%b exp 01", lanes_o[127], lanes_o[79]);
    end
    repeat (30) drive(1'b0, 2'd0);
    repeat (30) drive(1'b0, 2'd1);
    repeat (30) drive(1'b0, 2'd2);
    repeat (30) drive(1'b0, 2'd3);
    repeat (10) drive(1'b0, 2'd0);
    repeat (2)  drive(1'b1, 2'd3);
    repeat (10) drive(1'b0, 2'd3);
    drive(1'b0, 2'd1);
    drive(1'b0, 2'd2);
    drive(1'b0, 2'd1);
    drive(1'b0, 2'd1);
    repeat (3) drive(1'b0, 2'd3);
    repeat (5) drive(1'b0, 2'd0);
    drive(1'b1, 2'd2);
    repeat (8) drive(1'b0, 2'd2);
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule